// File: doc/BRIEF.md
# Banked General Register File

This block holds a processor's general-purpose registers: four banks, each with eight 8-bit registers. The same storage can also be read and written as four 16-bit register pairs. The active bank comes from two external select flags. Every coded access, whether byte or pair, goes to that bank only. The other banks keep their contents until they are selected again.

The datapath reaches the registers in three ways:

- **Byte access.** Two 3-bit-coded byte read ports and one byte write port.
- **Pair access.** A 2-bit-coded pair read port and a pair write port.
- **Accumulator access.** An implicit accumulator path for instructions that name no register. It exposes the byte accumulator and the 16-bit accumulator pair. It also has a dedicated 16-bit write-back, so a multiply product or a divide quotient lands in the accumulator pair in one clock.

The two pointer pairs are always driven out for address generation. All reads are combinational from the active bank. All writes take effect on the rising clock edge.

Top module: `bank_reg_file`

## Requirements
- R1: While rst_ni is low, and after it is released, every register in all four banks reads zero until it is written.
- R2: Byte codes 0..7 select the registers X, A, C, B, E, D, L, H in that order. A byte write to code c with wr_en_i high is visible on either byte read port, addressed with c, after the next rising edge.
- R3: Pair codes 0..3 select AX, BC, DE, HL. Pair p reads as {register 2p+1, register 2p}, so the odd code is the upper byte.
- R4: A pair write updates both component byte registers on the same rising edge.
- R5: The bank select value (0..3) picks the active bank for all reads and writes. Registers in the other banks do not change.
- R6: acc8_o always shows register A (code 1) of the active bank. acc16_o always shows pair AX (code 0) of the active bank.
- R7: With acc_wr_en_i high, all 16 bits of acc_wr_data_i are written into AX of the active bank in one edge: bits 15:8 go to A and bits 7:0 go to X.
- R8: When a byte write and a 16-bit write hit the same register in one cycle, the 16-bit value is stored in that register. A byte write to a register outside the written pair still takes effect in the same cycle.
- R9: When the accumulator write and a pair write to AX happen in one cycle, the accumulator data is stored. A pair write to another pair in the same cycle still takes effect.
- R10: ptr_de_o and ptr_hl_o always show pairs DE and HL of the active bank.
- R11: With all three write enables low, no register changes, whatever the write data and codes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 2 | Active bank select flags |
| rd_a_code_i | input | 3 | Byte read port A register code |
| rd_a_data_o | output | 8 | Byte read port A data |
| rd_b_code_i | input | 3 | Byte read port B register code |
| rd_b_data_o | output | 8 | Byte read port B data |
| wr_en_i | input | 1 | Byte write enable |
| wr_code_i | input | 3 | Byte write register code |
| wr_data_i | input | 8 | Byte write data |
| pair_rd_code_i | input | 2 | Pair read code |
| pair_rd_data_o | output | 16 | Pair read data |
| pair_wr_en_i | input | 1 | Pair write enable |
| pair_wr_code_i | input | 2 | Pair write code |
| pair_wr_data_i | input | 16 | Pair write data |
| acc_wr_en_i | input | 1 | Accumulator pair write enable |
| acc_wr_data_i | input | 16 | Accumulator pair write data |
| acc8_o | output | 8 | Byte accumulator A |
| acc16_o | output | 16 | Accumulator pair AX |
| ptr_de_o | output | 16 | Pointer pair DE |
| ptr_hl_o | output | 16 | Pointer pair HL |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a byte write landing in the very pair being written as 16 bits. The other is the accumulator write-back racing a pair write to AX. Only some byte lanes of these overlap.

Dedicated tasks fire all enables in one cycle. They cover a matching upper byte, a matching lower byte, and a disjoint target. Each time, every register of the bank is read back through both byte ports and the pair port.

Bank isolation is checked by filling one bank with distinct values. The bench then selects each other bank in turn and confirms that bank still holds its earlier contents.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned REG_CW    = $clog2(NUM_REGS);
  localparam int unsigned PAIR_CW   = REG_CW - 1;
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS);
  localparam int unsigned PAIR_W    = 2 * DATA_W;

  typedef enum logic [REG_CW-1:0] {
    REG_X, REG_A, REG_C, REG_B, REG_E, REG_D, REG_L, REG_H
  } reg_code_e;

  typedef enum logic [PAIR_CW-1:0] {
    PAIR_AX, PAIR_BC, PAIR_DE, PAIR_HL
  } pair_code_e;
endpackage

// File: rtl/bank_rf_rd_port.sv
module bank_rf_rd_port #(
  parameter int unsigned DW = bank_rf_pkg::DATA_W,
  parameter int unsigned NR = bank_rf_pkg::NUM_REGS,
  localparam int unsigned CW = $clog2(NR)
) (
  input  logic [NR-1:0][DW-1:0] bank_i,
  input  logic [CW-1:0]         code_i,
  output logic [DW-1:0]         data_o
);
  assign data_o = bank_i[code_i];
endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store #(
  parameter int unsigned DW = bank_rf_pkg::DATA_W,
  parameter int unsigned NB = bank_rf_pkg::NUM_BANKS,
  parameter int unsigned NR = bank_rf_pkg::NUM_REGS,
  localparam int unsigned RCW = $clog2(NR),
  localparam int unsigned PCW = RCW - 1,
  localparam int unsigned BW  = $clog2(NB),
  localparam int unsigned PW  = 2 * DW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BW-1:0]         bank_i,
  input  logic                  wr_en_i,
  input  logic [RCW-1:0]        wr_code_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic                  pwr_en_i,
  input  logic [PCW-1:0]        pwr_code_i,
  input  logic [PW-1:0]         pwr_data_i,
  input  logic                  acc_en_i,
  input  logic [PW-1:0]         acc_data_i,
  output logic [NR-1:0][DW-1:0] active_o
);
  logic [NR-1:0][DW-1:0] bank_q [NB];
  logic [NR-1:0][DW-1:0] bank_nxt;

  // later assignments win: byte < pair < accumulator
  always_comb begin
    bank_nxt = bank_q[bank_i];
    for (int r = 0; r < NR; r++) begin
      if (wr_en_i && wr_code_i == RCW'(r))
        bank_nxt[r] = wr_data_i;
      if (pwr_en_i && pwr_code_i == PCW'(r >> 1))
        bank_nxt[r] = r[0] ? pwr_data_i[PW-1:DW] : pwr_data_i[DW-1:0];
      if (acc_en_i && (r >> 1) == 0)
        bank_nxt[r] = r[0] ? acc_data_i[PW-1:DW] : acc_data_i[DW-1:0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bank_q[b] <= '0;
      else if (bank_i == BW'(b))
        bank_q[b] <= bank_nxt;
    end

    assert_bank_iso_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_i != BW'(b)) |=> $stable(bank_q[b]))
      else $error("R5 bank %0d changed while inactive", b);

    assert_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && !pwr_en_i && !acc_en_i) |=> $stable(bank_q[b]))
      else $error("R11 bank %0d changed with no write", b);
  end

  assign active_o = bank_q[bank_i];

  assert_pair_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && !(acc_en_i && pwr_code_i == '0)) |=>
      (bank_q[$past(bank_i)][{$past(pwr_code_i), 1'b1}] == $past(pwr_data_i[PW-1:DW]) &&
       bank_q[$past(bank_i)][{$past(pwr_code_i), 1'b0}] == $past(pwr_data_i[DW-1:0])))
    else $error("R4 pair write not stored");

  assert_acc_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> bank_q[$past(bank_i)][1:0] == $past(acc_data_i))
    else $error("R7 accumulator write not stored");

  assert_wide_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pwr_en_i && wr_code_i[RCW-1:1] == pwr_code_i &&
     !(acc_en_i && pwr_code_i == '0)) |=>
      bank_q[$past(bank_i)][$past(wr_code_i)] ==
        ($past(wr_code_i[0]) ? $past(pwr_data_i[PW-1:DW]) : $past(pwr_data_i[DW-1:0])))
    else $error("R8 byte write overrode pair write");
endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
  import bank_rf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [REG_CW-1:0] rd_a_code_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [REG_CW-1:0] rd_b_code_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [REG_CW-1:0] wr_code_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAIR_CW-1:0] pair_rd_code_i,
  output logic [PAIR_W-1:0] pair_rd_data_o,
  input  logic              pair_wr_en_i,
  input  logic [PAIR_CW-1:0] pair_wr_code_i,
  input  logic [PAIR_W-1:0] pair_wr_data_i,
  input  logic              acc_wr_en_i,
  input  logic [PAIR_W-1:0] acc_wr_data_i,
  output logic [DATA_W-1:0] acc8_o,
  output logic [PAIR_W-1:0] acc16_o,
  output logic [PAIR_W-1:0] ptr_de_o,
  output logic [PAIR_W-1:0] ptr_hl_o
);
  localparam int unsigned NUM_PAIRS = NUM_REGS / 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] active;
  logic [NUM_PAIRS-1:0][PAIR_W-1:0] pair_view;

  bank_rf_store #(.DW(DATA_W), .NB(NUM_BANKS), .NR(NUM_REGS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bank_i     (bank_sel_i),
    .wr_en_i    (wr_en_i),
    .wr_code_i  (wr_code_i),
    .wr_data_i  (wr_data_i),
    .pwr_en_i   (pair_wr_en_i),
    .pwr_code_i (pair_wr_code_i),
    .pwr_data_i (pair_wr_data_i),
    .acc_en_i   (acc_wr_en_i),
    .acc_data_i (acc_wr_data_i),
    .active_o   (active)
  );

  bank_rf_rd_port #(.DW(DATA_W), .NR(NUM_REGS)) u_rd_a (
    .bank_i (active), .code_i (rd_a_code_i), .data_o (rd_a_data_o)
  );

  bank_rf_rd_port #(.DW(DATA_W), .NR(NUM_REGS)) u_rd_b (
    .bank_i (active), .code_i (rd_b_code_i), .data_o (rd_b_data_o)
  );

  // even register is the low byte, so the packed bank is already a pair array
  assign pair_view      = active;
  assign pair_rd_data_o = pair_view[pair_rd_code_i];
  assign acc8_o         = active[REG_A];
  assign acc16_o        = pair_view[PAIR_AX];
  assign ptr_de_o       = pair_view[PAIR_DE];
  assign ptr_hl_o       = pair_view[PAIR_HL];

  assert_acc_alias_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_code_i == REG_A) |-> (rd_a_data_o == acc8_o && acc16_o[PAIR_W-1:DATA_W] == acc8_o))
    else $error("R6 accumulator outputs disagree with read port");

  assert_hl_alias_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_rd_code_i == PAIR_HL) |-> (pair_rd_data_o == ptr_hl_o))
    else $error("R10 pointer output disagrees with pair port");
endmodule

// File: tb/sim_bank_reg_file.sv
module sim_bank_reg_file;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bank_sel_i = '0;
  logic [2:0]  rd_a_code_i = '0, rd_b_code_i = '0, wr_code_i = '0;
  logic [7:0]  rd_a_data_o, rd_b_data_o, wr_data_i = '0, acc8_o;
  logic        wr_en_i = 1'b0, pair_wr_en_i = 1'b0, acc_wr_en_i = 1'b0;
  logic [1:0]  pair_rd_code_i = '0, pair_wr_code_i = '0;
  logic [15:0] pair_rd_data_o, pair_wr_data_i = '0, acc_wr_data_i = '0;
  logic [15:0] acc16_o, ptr_de_o, ptr_hl_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [4][8];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_reg_file u0 (.*);

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one write cycle; model applies byte, then pair, then accumulator
  task automatic cyc(input logic [1:0] b, input logic we, input logic [2:0] wc,
                     input logic [7:0] wd, input logic pe, input logic [1:0] pc,
                     input logic [15:0] pd, input logic ae, input logic [15:0] ad);
    @(negedge clk_i);
    bank_sel_i = b; wr_en_i = we; wr_code_i = wc; wr_data_i = wd;
    pair_wr_en_i = pe; pair_wr_code_i = pc; pair_wr_data_i = pd;
    acc_wr_en_i = ae; acc_wr_data_i = ad;
    @(negedge clk_i);
    wr_en_i = 1'b0; pair_wr_en_i = 1'b0; acc_wr_en_i = 1'b0;
    if (we) model[b][wc] = wd;
    if (pe) begin model[b][{pc,1'b1}] = pd[15:8]; model[b][{pc,1'b0}] = pd[7:0]; end
    if (ae) begin model[b][1] = ad[15:8]; model[b][0] = ad[7:0]; end
  endtask

  task automatic verify_bank(string req, input logic [1:0] b);
    bank_sel_i = b;
    for (int c = 0; c < 8; c++) begin
      rd_a_code_i = 3'(c); rd_b_code_i = 3'(7 - c);
      #1;
      chk(req, "rd_a", {8'h0, rd_a_data_o}, {8'h0, model[b][c]});
      chk(req, "rd_b", {8'h0, rd_b_data_o}, {8'h0, model[b][7-c]});
    end
    for (int p = 0; p < 4; p++) begin
      pair_rd_code_i = 2'(p);
      #1;
      chk(req, "pair", pair_rd_data_o, {model[b][2*p+1], model[b][2*p]});
    end
    chk(req, "acc8", {8'h0, acc8_o}, {8'h0, model[b][1]});
    chk(req, "acc16", acc16_o, {model[b][1], model[b][0]});
    chk(req, "ptr_de", ptr_de_o, {model[b][5], model[b][4]});
    chk(req, "ptr_hl", ptr_hl_o, {model[b][7], model[b][6]});
  endtask

  task automatic t_reset;
    for (int b = 0; b < 4; b++) verify_bank("R1", 2'(b));
  endtask

  task automatic t_byte_write;
    for (int c = 0; c < 8; c++) cyc(2'd0, 1'b1, 3'(c), 8'(8'h11 * (c + 1)), 1'b0, '0, '0, 1'b0, '0);
    verify_bank("R2", 2'd0);
    rd_a_code_i = 3'd1; #1;
    chk("R6", "A via code 1", {8'h0, rd_a_data_o}, 16'h0022);
    verify_bank("R3", 2'd0);
  endtask

  task automatic t_pair_write;
    cyc(2'd2, 1'b0, '0, '0, 1'b1, 2'd2, 16'hD5E4, 1'b0, '0);
    cyc(2'd2, 1'b0, '0, '0, 1'b1, 2'd3, 16'h8A6B, 1'b0, '0);
    bank_sel_i = 2'd2; rd_a_code_i = 3'd5; rd_b_code_i = 3'd4; #1;
    chk("R4", "D", {8'h0, rd_a_data_o}, 16'h00D5);
    chk("R4", "E", {8'h0, rd_b_data_o}, 16'h00E4);
    chk("R10", "de", ptr_de_o, 16'hD5E4);
    chk("R10", "hl", ptr_hl_o, 16'h8A6B);
    verify_bank("R4", 2'd2);
  endtask

  task automatic t_bank_iso;
    for (int c = 0; c < 8; c++) cyc(2'd3, 1'b1, 3'(c), 8'(8'hA0 + c), 1'b0, '0, '0, 1'b0, '0);
    cyc(2'd3, 1'b0, '0, '0, 1'b1, 2'd1, 16'hBBCC, 1'b1, 16'h1357);
    for (int b = 0; b < 4; b++) verify_bank("R5", 2'(b));
  endtask

  task automatic t_acc;
    cyc(2'd1, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 16'hFE01);
    bank_sel_i = 2'd1; #1;
    chk("R7", "acc16", acc16_o, 16'hFE01);
    chk("R6", "acc8", {8'h0, acc8_o}, 16'h00FE);
    verify_bank("R7", 2'd1);
  endtask

  task automatic t_conflict8;
    cyc(2'd0, 1'b1, 3'd7, 8'h77, 1'b1, 2'd3, 16'h9C3D, 1'b0, '0);
    bank_sel_i = 2'd0; rd_a_code_i = 3'd7; #1;
    chk("R8", "H upper clash", {8'h0, rd_a_data_o}, 16'h009C);
    cyc(2'd0, 1'b1, 3'd4, 8'h44, 1'b1, 2'd2, 16'h5A6B, 1'b0, '0);
    rd_a_code_i = 3'd4; #1;
    chk("R8", "E lower clash", {8'h0, rd_a_data_o}, 16'h006B);
    cyc(2'd0, 1'b1, 3'd2, 8'h2F, 1'b1, 2'd3, 16'h0102, 1'b0, '0);
    rd_a_code_i = 3'd2; #1;
    chk("R8", "C disjoint", {8'h0, rd_a_data_o}, 16'h002F);
    verify_bank("R8", 2'd0);
  endtask

  task automatic t_conflict_acc;
    cyc(2'd1, 1'b1, 3'd1, 8'h99, 1'b1, 2'd0, 16'h1111, 1'b1, 16'hABCD);
    bank_sel_i = 2'd1; #1;
    chk("R9", "acc over pair", acc16_o, 16'hABCD);
    cyc(2'd1, 1'b0, '0, '0, 1'b1, 2'd1, 16'h4321, 1'b1, 16'h0F0E);
    #1;
    chk("R9", "acc", acc16_o, 16'h0F0E);
    pair_rd_code_i = 2'd1; #1;
    chk("R9", "bc alongside", pair_rd_data_o, 16'h4321);
    verify_bank("R9", 2'd1);
  endtask

  task automatic t_idle;
    for (int b = 0; b < 4; b++)
      cyc(2'(b), 1'b0, 3'd3, 8'h5C, 1'b0, 2'd2, 16'hFFFF, 1'b0, 16'hEEEE);
    for (int b = 0; b < 4; b++) verify_bank("R11", 2'(b));
  endtask

  initial begin
    for (int b = 0; b < 4; b++) for (int c = 0; c < 8; c++) model[b][c] = '0;
    repeat (2) @(negedge clk_i);
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_byte_write();
    t_pair_write();
    t_bank_iso();
    t_acc();
    t_conflict8();
    t_conflict_acc();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule